// File: doc/BRIEF.md
# TDM Codec Serial Slot Interface

This block is a time-division-multiplexed serial port for audio codecs. It runs on a fast system clock and watches an external bit clock, detecting its edges. A frame is divided into slots (1 to 16), each slot into bits (1 to 16). In every slot, a receive enable and a transmit enable decide whether a word is captured from the serial input, sent on the serial output, or both. A 16-bit-per-word transmit buffer, presented as a flat input vector, and a receive buffer, presented as a flat output vector, are indexed by one shared word pointer. The pointer restarts at zero at each frame.

The frame marker is either produced by the block (master) or taken from the pin (slave). The edge on which serial inputs are sampled can be selected. The first data bit can sit in the bit period that follows the marker or in the same period as the marker. A slot with no transmit word can either drive zero or release the output.

Top module: `tdm_slot_port`

## Requirements
- R1: With `sampleRise`=0, `sdi` and the frame marker are sampled on falling `bitClk` edges. With `sampleRise`=1 they are sampled on rising edges. `sdo`, `sdoOe` and `fsOut` only change after the opposite edge.
- R2: With `sameCycleStart`=0, slot 0 bit 0 occupies the bit period after the one in which the frame marker is sampled high.
- R3: With `sameCycleStart`=1, slot 0 bit 0 occupies the same bit period as the frame marker.
- R4: A slot lasts `wordLenM1`+1 bit periods and a frame holds `frameLenM1`+1 slots, so a frame lasts their product in bit periods.
- R5: In a transmit-enabled slot, `sdo` sends buffer word [pointer], most significant bit first, starting at bit 15. The low 16−L bits are never sent.
- R6: In a slot that is not transmitting, `sdo` is 0. `sdoOe` is 0 there when `idleHiZ`=1 and 1 otherwise. In a transmitting slot, `sdoOe` is 1.
- R7: At the end of a receive-enabled slot, the L received bits are written to `rxWords` word [pointer], left-justified: the first bit received lands at bit 15 and the lower bits are 0.
- R8: The shared pointer advances by one after every slot that is enabled for transmit or receive. A transmit-only slot leaves its receive word unchanged.
- R9: The pointer returns to 0 at each frame start. Once it equals `bufDepthM1`+1, later slots in that frame neither send buffer data nor write received data.
- R10: `bufDone` pulses for exactly one clock when the pointer reaches `bufDepthM1`+1, at most once per frame.
- R11: Enable bits for slot numbers at or above `frameLenM1`+1 have no effect.
- R12: In master mode, `fsOut` is high for the one bit period that begins each frame, repeating every frame length. In slave mode, `fsOut` stays 0 and `fsIn` starts each frame.
- R13: After the last slot of a frame, nothing is sent or stored until the next frame marker. With `sameCycleStart`=0, the output is idle in that time.
- R14: During reset, `sdo`, `sdoOe`, `fsOut`, `bufDone` and every receive word are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleRise | input | 1 | 1: sample on rising `bitClk`; 0: on falling |
| sameCycleStart | input | 1 | 1: data starts in the marker period |
| idleHiZ | input | 1 | 1: release `sdo` in slots that are not transmitting |
| masterMode | input | 1 | 1: the block generates the frame marker |
| wordLenM1 | input | 4 | Bits per slot minus one |
| frameLenM1 | input | 4 | Slots per frame minus one |
| bufDepthM1 | input | $clog2(DEPTH) | Buffer words used per frame minus one |
| txSlotEn | input | 16 | Transmit enable per slot |
| rxSlotEn | input | 16 | Receive enable per slot |
| txWords | input | DEPTH*16 | Transmit buffer, word i at bits [16i+15:16i] |
| rxWords | output | DEPTH*16 | Receive buffer, same layout |
| bitClk | input | 1 | Serial bit clock |
| fsIn | input | 1 | Frame marker in slave mode |
| fsOut | output | 1 | Frame marker in master mode |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Output enable for `sdo` |
| bufDone | output | 1 | One-clock strobe when the buffer window is used up |

## Verification
Every result is due a fixed number of system clocks after a `bitClk` edge. After a drive edge, `sdo`, `sdoOe` and `fsOut` settle one clock later. After a sample edge, a completed slot's receive word and any `bufDone` pulse appear one clock later. The bench holds each `bitClk` level for two clocks and reads the serial outputs just before the next sample edge, which is a full clock after they must have settled. It reads the receive buffer and the count of `bufDone` pulses only after the last frame of a configuration has ended.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
  localparam int WORD_W   = 16;
  localparam int SLOT_MAX = 16;
  localparam int IDX_W    = $clog2(SLOT_MAX);

  typedef struct packed {
    logic sampleEv;
    logic driveEv;
    logic shiftBit;
    logic writeWord;
    logic txOn;
  } tdmStrobes_t;
endpackage

// File: rtl/tdm_slot_ctrl.sv
module tdm_slot_ctrl
  import tdm_slot_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH + 1),
  localparam int DW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitClk,
  input  logic                fsIn,
  input  logic                sampleRise,
  input  logic                sameCycleStart,
  input  logic                masterMode,
  input  logic [IDX_W-1:0]    wordLenM1,
  input  logic [IDX_W-1:0]    frameLenM1,
  input  logic [DW-1:0]       bufDepthM1,
  input  logic [SLOT_MAX-1:0] txSlotEn,
  input  logic [SLOT_MAX-1:0] rxSlotEn,
  output tdmStrobes_t         strb,
  output logic [PTR_W-1:0]    rxPtr,
  output logic [PTR_W-1:0]    drvPtr,
  output logic [IDX_W-1:0]    drvBit,
  output logic                fsOut,
  output logic                bufDone
);
  localparam int CNT_W = 2 * IDX_W + 1;

  logic bitClkQ;
  logic riseEv, fallEv, sampleEv, driveEv;
  logic active;
  logic [IDX_W-1:0] slotIdx, bitIdx;
  logic [PTR_W-1:0] ptr, depthW;
  logic [CNT_W-1:0] mCnt, frameBits, frameBitsM1;
  logic fsOutQ, doneQ;

  always_ff @(posedge clk) bitClkQ <= bitClk;

  assign riseEv   = bitClk & ~bitClkQ;
  assign fallEv   = ~bitClk & bitClkQ;
  assign sampleEv = sampleRise ? riseEv : fallEv;
  assign driveEv  = sampleRise ? fallEv : riseEv;

  assign depthW      = PTR_W'(bufDepthM1) + PTR_W'(1);
  assign frameBits   = (CNT_W'(wordLenM1) + CNT_W'(1)) * (CNT_W'(frameLenM1) + CNT_W'(1));
  assign frameBitsM1 = frameBits - CNT_W'(1);

  // Sample side: which bit is being captured at this edge
  logic fsSeen, startNow, restartNext;
  logic [IDX_W-1:0] curSlot, curBit;
  logic [PTR_W-1:0] curPtr, ptrNext;
  logic doBit, bitLast, slotLast, ptrRoom, slotUsed, endSlot, writeWord, advance;

  assign fsSeen      = masterMode ? fsOutQ : fsIn;
  assign startNow    = sampleEv & fsSeen & sameCycleStart;
  assign restartNext = sampleEv & fsSeen & ~sameCycleStart;
  assign curSlot     = startNow ? '0 : slotIdx;
  assign curBit      = startNow ? '0 : bitIdx;
  assign curPtr      = startNow ? '0 : ptr;
  assign doBit       = sampleEv & (startNow | active);
  assign bitLast     = (curBit == wordLenM1);
  assign slotLast    = (curSlot == frameLenM1);
  assign ptrRoom     = (curPtr < depthW);
  assign slotUsed    = txSlotEn[curSlot] | rxSlotEn[curSlot];
  assign endSlot     = doBit & bitLast;
  assign writeWord   = endSlot & rxSlotEn[curSlot] & ptrRoom;
  assign advance     = endSlot & slotUsed & ptrRoom;
  assign ptrNext     = curPtr + PTR_W'(advance);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      slotIdx <= '0;
      bitIdx  <= '0;
      ptr     <= '0;
      mCnt    <= '0;
      fsOutQ  <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= advance && (ptrNext == depthW);
      if (doBit) begin
        ptr <= ptrNext;
        if (bitLast) begin
          bitIdx <= '0;
          if (slotLast) begin
            slotIdx <= '0;
            active  <= 1'b0;
          end else begin
            slotIdx <= curSlot + IDX_W'(1);
            active  <= 1'b1;
          end
        end else begin
          bitIdx  <= curBit + IDX_W'(1);
          slotIdx <= curSlot;
          active  <= 1'b1;
        end
      end
      if (restartNext) begin
        active  <= 1'b1;
        slotIdx <= '0;
        bitIdx  <= '0;
        ptr     <= '0;
      end
      if (masterMode && sampleEv)
        mCnt <= (mCnt == frameBitsM1) ? '0 : mCnt + CNT_W'(1);
      if (driveEv)
        fsOutQ <= masterMode && (mCnt == '0);
    end
  end

  // Drive side: the bit to present before the next sample edge
  logic drvLive;
  logic [IDX_W-1:0] drvSlot;
  assign drvLive = active | sameCycleStart;
  assign drvSlot = active ? slotIdx : '0;
  assign drvBit  = active ? bitIdx : '0;
  assign drvPtr  = active ? ptr : '0;

  assign strb.sampleEv  = sampleEv;
  assign strb.driveEv   = driveEv;
  assign strb.shiftBit  = doBit;
  assign strb.writeWord = writeWord;
  assign strb.txOn      = drvLive & txSlotEn[drvSlot] & (drvPtr < depthW);
  assign rxPtr   = curPtr;
  assign fsOut   = fsOutQ;
  assign bufDone = doneQ;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) bufDone |=> !bufDone); // R10
  AST_PTR_LIMIT: assert property (@(posedge clk) disable iff (!rstN) ptr <= depthW); // R9
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rstN) !masterMode |=> !fsOut); // R12
  AST_FS_ON_DRIVE: assert property (@(posedge clk) disable iff (!rstN) !driveEv |=> $stable(fsOut)); // R1
endmodule

// File: rtl/tdm_slot_dp.sv
module tdm_slot_dp
  import tdm_slot_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH + 1),
  localparam int DW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  tdmStrobes_t             strb,
  input  logic [PTR_W-1:0]        rxPtr,
  input  logic [PTR_W-1:0]        drvPtr,
  input  logic [IDX_W-1:0]        drvBit,
  input  logic [IDX_W-1:0]        wordLenM1,
  input  logic                    idleHiZ,
  input  logic                    sdi,
  input  logic [DEPTH*WORD_W-1:0] txWords,
  output logic [DEPTH*WORD_W-1:0] rxWords,
  output logic                    sdo,
  output logic                    sdoOe
);
  logic [WORD_W-1:0] txArr [DEPTH];
  logic [WORD_W-1:0] rxMem [DEPTH];
  logic [WORD_W-1:0] rxSh, shNext, justified;
  logic [IDX_W-1:0]  bitSel;
  logic              txBitVal;

  assign shNext    = {rxSh[WORD_W-2:0], sdi};
  assign justified = shNext << (IDX_W'(WORD_W - 1) - wordLenM1);
  assign bitSel    = IDX_W'(WORD_W - 1) - drvBit;
  assign txBitVal  = txArr[drvPtr[DW-1:0]][bitSel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSh  <= '0;
      sdo   <= 1'b0;
      sdoOe <= 1'b0;
    end else begin
      if (strb.shiftBit) rxSh <= shNext;
      if (strb.driveEv) begin
        sdo   <= strb.txOn & txBitVal;
        sdoOe <= strb.txOn | ~idleHiZ;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gWord
    assign txArr[g] = txWords[g*WORD_W +: WORD_W];
    always_ff @(posedge clk) begin
      if (!rstN) rxMem[g] <= '0;
      else if (strb.writeWord && (rxPtr == PTR_W'(g))) rxMem[g] <= justified;
    end
    assign rxWords[g*WORD_W +: WORD_W] = rxMem[g];
  end

  AST_SDO_ON_DRIVE: assert property (@(posedge clk) disable iff (!rstN) !strb.driveEv |=> ($stable(sdo) && $stable(sdoOe))); // R1
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN) !sdoOe |-> !sdo); // R6
  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN) strb.writeWord |-> (rxPtr < PTR_W'(DEPTH))); // R9
endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port
  import tdm_slot_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int DW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleRise,
  input  logic                    sameCycleStart,
  input  logic                    idleHiZ,
  input  logic                    masterMode,
  input  logic [IDX_W-1:0]        wordLenM1,
  input  logic [IDX_W-1:0]        frameLenM1,
  input  logic [DW-1:0]           bufDepthM1,
  input  logic [SLOT_MAX-1:0]     txSlotEn,
  input  logic [SLOT_MAX-1:0]     rxSlotEn,
  input  logic [DEPTH*WORD_W-1:0] txWords,
  output logic [DEPTH*WORD_W-1:0] rxWords,
  input  logic                    bitClk,
  input  logic                    fsIn,
  output logic                    fsOut,
  input  logic                    sdi,
  output logic                    sdo,
  output logic                    sdoOe,
  output logic                    bufDone
);
  tdmStrobes_t      strb;
  logic [PTR_W-1:0] rxPtr, drvPtr;
  logic [IDX_W-1:0] drvBit;

  tdm_slot_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .fsIn(fsIn),
    .sampleRise(sampleRise), .sameCycleStart(sameCycleStart), .masterMode(masterMode),
    .wordLenM1(wordLenM1), .frameLenM1(frameLenM1), .bufDepthM1(bufDepthM1),
    .txSlotEn(txSlotEn), .rxSlotEn(rxSlotEn),
    .strb(strb), .rxPtr(rxPtr), .drvPtr(drvPtr), .drvBit(drvBit),
    .fsOut(fsOut), .bufDone(bufDone)
  );

  tdm_slot_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxPtr(rxPtr), .drvPtr(drvPtr),
    .drvBit(drvBit), .wordLenM1(wordLenM1), .idleHiZ(idleHiZ), .sdi(sdi),
    .txWords(txWords), .rxWords(rxWords), .sdo(sdo), .sdoOe(sdoOe)
  );
endmodule

// File: tb/tdm_slot_port_tb.sv
`timescale 1ns/1ps
module tdm_slot_port_tb;
  localparam int DEPTH = 8;
  localparam int NCFG = 24;
  localparam int NFR = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, sampleRise, sameCycleStart, idleHiZ, masterMode;
  logic [3:0] wordLenM1, frameLenM1;
  logic [2:0] bufDepthM1;
  logic [15:0] txSlotEn, rxSlotEn;
  logic [DEPTH*16-1:0] txWords, rxWords;
  logic bitClk, fsIn, fsOut, sdi, sdo, sdoOe, bufDone;

  tdm_slot_port #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .sampleRise(sampleRise), .sameCycleStart(sameCycleStart),
    .idleHiZ(idleHiZ), .masterMode(masterMode), .wordLenM1(wordLenM1),
    .frameLenM1(frameLenM1), .bufDepthM1(bufDepthM1), .txSlotEn(txSlotEn),
    .rxSlotEn(rxSlotEn), .txWords(txWords), .rxWords(rxWords), .bitClk(bitClk),
    .fsIn(fsIn), .fsOut(fsOut), .sdi(sdi), .sdo(sdo), .sdoOe(sdoOe), .bufDone(bufDone)
  );

  int checks = 0, fails = 0, cyc = 0, doneCnt = 0;
  int cfgIdx, L, S, D, T, gap, off;
  logic [15:0] txw [DEPTH];
  logic [15:0] expRx [DEPTH];

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cfg %0d %s actual=%0h expected=%0h", req, cfgIdx, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rstN === 1'b1 && bufDone === 1'b1) doneCnt++;
    if (cyc == 190000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  function automatic int ptrAt(int s);
    int p = 0;
    for (int j = 0; j < s; j++)
      if ((txSlotEn[j] || rxSlotEn[j]) && p < D) p++;
    return p;
  endfunction

  function automatic logic [15:0] rxPat(int f, int s);
    return 16'((f * 977 + s * 331 + cfgIdx * 53) ^ 16'hA5C3);
  endfunction

  task automatic runCfg(input int c);
    int used, lastP;
    cfgIdx = c;
    L = (c * 7) % 16 + 1;
    S = (c * 5 + 3) % 16 + 1;
    D = c % 8 + 1;
    T = L * S;
    sampleRise = c[0]; sameCycleStart = c[1]; idleHiZ = c[2]; masterMode = c[3];
    gap = masterMode ? 0 : 3;
    off = sameCycleStart ? 0 : 1;
    wordLenM1 = 4'(L - 1); frameLenM1 = 4'(S - 1); bufDepthM1 = 3'(D - 1);
    txSlotEn = 16'(32'hB5A3 >> (c % 5)) ^ 16'(c * 16'h0909);
    rxSlotEn = 16'h6C39 ^ 16'(c * 16'h1111);
    for (int i = 0; i < DEPTH; i++) begin
      txw[i] = 16'((i + 1) * 16'h9E37 + c * 16'h0B17);
      txWords[i*16 +: 16] = txw[i];
      expRx[i] = 16'h0;
    end
    rstN = 1'b0; bitClk = sampleRise; fsIn = 1'b0; sdi = 1'b0;
    repeat (4) @(negedge clk);
    chk(sdo === 1'b0 && sdoOe === 1'b0, "R14", "sdo/oe in reset", {sdo, sdoOe}, 0);
    chk(fsOut === 1'b0 && bufDone === 1'b0, "R14", "fsOut/bufDone in reset", {fsOut, bufDone}, 0);
    chk(rxWords === '0, "R14", "rx buffer in reset", int'(rxWords[31:0]), 0);
    doneCnt = 0;
    rstN = 1'b1;
    @(negedge clk);
    used = 0;
    for (int j = 0; j < S; j++) if (txSlotEn[j] || rxSlotEn[j]) used++;
    lastP = (NFR - 1) * (T + gap) + T - 1 + off;
    for (int p = 0; p <= lastP; p++) begin
      int pp, f2, k, s, b, ptr;
      bit isData, expOn, expSdo, expOe, fsNow;
      fsNow = !masterMode && (p % (T + gap) == 0) && (p / (T + gap) < NFR);
      pp = p - off;
      isData = (pp >= 0) && ((pp % (T + gap)) < T) && ((pp / (T + gap)) < NFR);
      f2 = isData ? pp / (T + gap) : 0;
      k = isData ? pp % (T + gap) : 0;
      s = k / L; b = k % L;
      ptr = ptrAt(s);
      // drive edge
      bitClk = ~bitClk;
      fsIn = fsNow;
      sdi = isData ? rxPat(f2, s)[L - 1 - b] : ((p * 7) % 3 == 0);
      repeat (2) @(negedge clk);
      if (isData) begin
        expOn = txSlotEn[s] && ptr < D;
        expSdo = expOn ? txw[ptr][15 - b] : 1'b0;
        expOe = expOn || !idleHiZ;
        if (k == 0)
          chk(sdo === expSdo && sdoOe === expOe, sameCycleStart ? "R3" : "R2",
              "first bit of frame", {sdo, sdoOe}, {expSdo, expOe});
        else if (expOn)
          chk(sdo === expSdo && sdoOe === 1'b1, "R5", "tx bit", {sdo, sdoOe}, {expSdo, 1'b1});
        else if (txSlotEn[s])
          chk(sdo === 1'b0 && sdoOe === expOe, "R9", "tx past buffer end", {sdo, sdoOe}, {1'b0, expOe});
        else
          chk(sdo === 1'b0 && sdoOe === expOe, "R6", "disabled tx slot", {sdo, sdoOe}, {1'b0, expOe});
        if (b == L - 1 && rxSlotEn[s] && ptr < D)
          expRx[ptr] = 16'(((int'(rxPat(f2, s)) & ((1 << L) - 1)) << (16 - L)) & 16'hFFFF);
      end else if (!sameCycleStart) begin
        chk(sdo === 1'b0 && sdoOe === !idleHiZ, "R13", "idle between frames", {sdo, sdoOe}, {1'b0, !idleHiZ});
      end
      chk(fsOut === (masterMode && (p % T == 0)), "R12", "frame marker out", fsOut,
          int'(masterMode && (p % T == 0)));
      // sample edge
      bitClk = ~bitClk;
      repeat (2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    for (int i = 0; i < DEPTH; i++)
      chk(rxWords[i*16 +: 16] === expRx[i], "R1 R4 R7 R8 R11", "rx word", int'(rxWords[i*16 +: 16]), int'(expRx[i]));
    chk(doneCnt == NFR * int'(used >= D), "R10", "bufDone pulses", doneCnt, NFR * int'(used >= D));
  endtask

  initial begin
    rstN = 1'b0; bitClk = 1'b0; fsIn = 1'b0; sdi = 1'b0; txWords = '0;
    for (int c = 0; c < NCFG; c++) runCfg(c);
    summary();
    $finish;
  end
endmodule